// File: doc/BRIEF.md
# Distributed Cluster-Merging Grid for a Union-Find Decoder

This block is a rectangular array of processing elements, one per detector vertex, that carries out the grow and merge phases of a union-find cluster decoder. Each element has a fixed id given by its position. A caller presents a bitmap of defects and pulses a start input. A small controller then runs merge and grow stages one after the other. In a merge stage, elements swap cluster ids and parity flags with their four-connected neighbours every cycle. The controller leaves a merge stage only after a cycle in which nothing in the grid changed.

Cluster formation is fully local. An element linked to a neighbour through a fully grown edge takes that neighbour's id if it is smaller, and points its parent pointer at it. Each element recomputes the parity of its subtree every cycle from its own defect and from the children that point at it. The root of a cluster turns its subtree parity into the cluster parity, and that flag then spreads outward one hop per cycle. When every cluster is even, the block raises done and shows the final cluster id of each element. A cycle limit ends any decode that cannot finish, and the block then raises an error flag instead.

Top module: `uf_grid_decoder`

## Requirements
- R1: After rst_ni is low, or after any clock edge at which start_i is high, done_o and error_o are 0 and every element's cluster id equals its own id. Element id k = row*COLS+col sits on cid_o[k*ID_W +: ID_W], and defect_i bit k is the defect of element k.
- R2: Each edge between four-connected neighbours starts at growth 0. Every grow stage adds one for each endpoint whose cluster has odd parity, saturating at weight 2. An edge is fully grown at 2.
- R3: While done_o is high, each element's cluster id is the smallest id among all elements joined to it through fully grown edges.
- R4: done_o rises only after a merge cycle with no change anywhere in which every cluster holds an even number of defects. It then stays high and the ids stay stable until the next start, and it is never high together with error_o.
- R5: A decode still unfinished CYCLE_LIMIT clock edges after the start edge ends with error_o high, held until the next start. A bitmap with an odd number of defects always ends this way, because the grid has no boundary.
- R6: A start pulse during a running decode abandons it and decodes the newly sampled bitmap from the initial state.
- R7: busy_o is high in any merge cycle in which some element is about to change state, or in which a fully grown edge joins elements with different ids. It is low while done_o is high.
- R8: With an empty bitmap, done_o is high one clock edge after the start edge, and every element keeps its own id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Samples defect_i, clears all state and starts a decode |
| defect_i | input | N_PE | Defect bitmap, bit k for element k |
| busy_o | output | 1 | Some element is changing or a merge is pending |
| done_o | output | 1 | Decode finished with all clusters even |
| error_o | output | 1 | Cycle limit reached without finishing |
| cid_o | output | N_PE*ID_W | Cluster id of each element, element k at bits k*ID_W |

## Verification
Several things can happen to one element in the same merge cycle. It can take a smaller id from a neighbour while its subtree parity is still being computed through children whose pointers have gone stale. A root can also stop being a root in the very cycle its parity would have been published. The bench provokes these cases by sweeping all 512 bitmaps of a 3x3 grid, so chains, L-shapes and clusters that meet from several sides all occur. Each outcome is judged against an arithmetic model in the bench that grows edge counters and labels connected components by minimum id, comparing the done or error outcome and every final id.

// File: rtl/uf_pkg.sv
package uf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MERGE,
    ST_GROW,
    ST_DONE,
    ST_FAIL
  } stage_e;

  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;
endpackage

// File: rtl/uf_pe.sv
module uf_pe
  import uf_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int WEIGHT = 2,
  parameter int MY_ID  = 0,
  parameter bit HAS_E  = 1'b1,
  parameter bit HAS_S  = 1'b1,
  localparam int GROW_W = $clog2(WEIGHT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 defect_i,
  input  logic                 grow_en_i,
  input  logic                 merge_en_i,
  input  logic [3:0][ID_W-1:0] nb_cid_i,
  input  logic [3:0]           nb_odd_i,
  input  logic [3:0]           nb_st_odd_i,
  input  logic [3:0]           nb_to_me_i,
  input  logic                 grown_n_i,
  input  logic                 grown_w_i,
  output logic [ID_W-1:0]      cid_o,
  output logic                 odd_o,
  output logic                 st_odd_o,
  output logic [3:0]           par_o,
  output logic                 grown_e_o,
  output logic                 grown_s_o,
  output logic                 root_odd_o,
  output logic                 busy_o
);
  localparam logic [ID_W-1:0]   OWN_ID = ID_W'(MY_ID);
  localparam logic [GROW_W-1:0] FULL   = GROW_W'(WEIGHT);

  logic [ID_W-1:0]   cid_q, cid_n, best_cid;
  logic [3:0]        par_q, par_n, best_dir, grown, edge_busy;
  logic              st_odd_q, st_odd_n, odd_q, odd_n, def_q;
  logic [GROW_W-1:0] gr_e_q, gr_s_q, gr_e_n, gr_s_n;
  logic              is_root, changed;

  function automatic logic [GROW_W-1:0] sat_add(logic [GROW_W-1:0] g, logic a, logic b);
    int s;
    s = int'(g) + int'(a) + int'(b);
    return (s >= WEIGHT) ? FULL : GROW_W'(s);
  endfunction

  assign grown[DIR_N] = grown_n_i;
  assign grown[DIR_W] = grown_w_i;
  assign grown[DIR_E] = HAS_E && (gr_e_q == FULL);
  assign grown[DIR_S] = HAS_S && (gr_s_q == FULL);

  // edge counters: only east and south edges live here (lower id end)
  assign gr_e_n = HAS_E ? sat_add(gr_e_q, odd_q, nb_odd_i[DIR_E]) : gr_e_q;
  assign gr_s_n = HAS_S ? sat_add(gr_s_q, odd_q, nb_odd_i[DIR_S]) : gr_s_q;

  always_comb begin
    best_cid = cid_q;
    best_dir = '0;
    for (int d = 0; d < 4; d++) begin
      if (grown[d] && (nb_cid_i[d] < best_cid)) begin
        best_cid    = nb_cid_i[d];
        best_dir    = '0;
        best_dir[d] = 1'b1;
      end
    end
  end

  assign is_root  = (cid_q == OWN_ID);
  assign cid_n    = best_cid;
  assign par_n    = (best_dir != '0) ? best_dir : par_q;
  assign st_odd_n = def_q ^ (^(nb_st_odd_i & nb_to_me_i & grown));
  assign odd_n    = is_root ? st_odd_q : |(nb_odd_i & par_q);

  assign changed = merge_en_i && ((cid_n != cid_q) || (par_n != par_q) ||
                                  (st_odd_n != st_odd_q) || (odd_n != odd_q));

  always_comb begin
    for (int d = 0; d < 4; d++) edge_busy[d] = grown[d] && (nb_cid_i[d] != cid_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cid_q    <= OWN_ID;
      par_q    <= '0;
      st_odd_q <= 1'b0;
      odd_q    <= 1'b0;
      def_q    <= 1'b0;
      gr_e_q   <= '0;
      gr_s_q   <= '0;
    end else if (clear_i) begin
      cid_q    <= OWN_ID;
      par_q    <= '0;
      st_odd_q <= defect_i;
      odd_q    <= defect_i;
      def_q    <= defect_i;
      gr_e_q   <= '0;
      gr_s_q   <= '0;
    end else begin
      if (grow_en_i) begin
        gr_e_q <= gr_e_n;
        gr_s_q <= gr_s_n;
      end
      if (merge_en_i) begin
        cid_q    <= cid_n;
        par_q    <= par_n;
        st_odd_q <= st_odd_n;
        odd_q    <= odd_n;
      end
    end
  end

  assign cid_o      = cid_q;
  assign odd_o      = odd_q;
  assign st_odd_o   = st_odd_q;
  assign par_o      = par_q;
  assign grown_e_o  = grown[DIR_E];
  assign grown_s_o  = grown[DIR_S];
  assign root_odd_o = is_root && odd_q;
  assign busy_o     = (|edge_busy) || changed;
endmodule

// File: rtl/uf_ctrl.sv
module uf_ctrl
  import uf_pkg::*;
#(
  parameter int CYCLE_LIMIT = 400,
  localparam int CNT_W = $clog2(CYCLE_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic grid_busy_i,
  input  logic any_odd_i,
  output logic grow_en_o,
  output logic merge_en_o,
  output logic done_o,
  output logic error_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LIMIT - 1);

  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      stage_q <= ST_MERGE;
      cnt_q   <= '0;
    end else begin
      unique case (stage_q)
        ST_MERGE: begin
          if (cnt_q == LAST) stage_q <= ST_FAIL;
          else begin
            cnt_q <= cnt_q + 1'b1;
            if (!grid_busy_i) stage_q <= any_odd_i ? ST_GROW : ST_DONE;
          end
        end
        ST_GROW: begin
          if (cnt_q == LAST) stage_q <= ST_FAIL;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            stage_q <= ST_MERGE;
          end
        end
        default: ;
      endcase
    end
  end

  assign merge_en_o = (stage_q == ST_MERGE);
  assign grow_en_o  = (stage_q == ST_GROW);
  assign done_o     = (stage_q == ST_DONE);
  assign error_o    = (stage_q == ST_FAIL);
endmodule

// File: rtl/uf_grid_decoder.sv
module uf_grid_decoder
  import uf_pkg::*;
#(
  parameter int ROWS        = 3,
  parameter int COLS        = 3,
  parameter int WEIGHT      = 2,
  parameter int CYCLE_LIMIT = 400,
  localparam int N_PE = ROWS * COLS,
  localparam int ID_W = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [N_PE-1:0]      defect_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 error_o,
  output logic [N_PE*ID_W-1:0] cid_o
);
  logic [N_PE-1:0][ID_W-1:0] cid_v;
  logic [N_PE-1:0][3:0]      par_v;
  logic [N_PE-1:0]           odd_v, st_v, ge_v, gs_v, root_odd_v, busy_v;
  logic                      grow_en, merge_en, grid_busy;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      logic [3:0][ID_W-1:0] nb_cid;
      logic [3:0]           nb_odd, nb_st, nb_to_me;
      logic                 gn, gw;

      if (r > 0) begin : g_n
        assign nb_cid[DIR_N]   = cid_v[K-COLS];
        assign nb_odd[DIR_N]   = odd_v[K-COLS];
        assign nb_st[DIR_N]    = st_v[K-COLS];
        assign nb_to_me[DIR_N] = par_v[K-COLS][DIR_S];
        assign gn              = gs_v[K-COLS];
      end else begin : g_nn
        assign nb_cid[DIR_N]   = '0;
        assign nb_odd[DIR_N]   = 1'b0;
        assign nb_st[DIR_N]    = 1'b0;
        assign nb_to_me[DIR_N] = 1'b0;
        assign gn              = 1'b0;
      end
      if (r < ROWS - 1) begin : g_s
        assign nb_cid[DIR_S]   = cid_v[K+COLS];
        assign nb_odd[DIR_S]   = odd_v[K+COLS];
        assign nb_st[DIR_S]    = st_v[K+COLS];
        assign nb_to_me[DIR_S] = par_v[K+COLS][DIR_N];
      end else begin : g_ns
        assign nb_cid[DIR_S]   = '0;
        assign nb_odd[DIR_S]   = 1'b0;
        assign nb_st[DIR_S]    = 1'b0;
        assign nb_to_me[DIR_S] = 1'b0;
      end
      if (c > 0) begin : g_w
        assign nb_cid[DIR_W]   = cid_v[K-1];
        assign nb_odd[DIR_W]   = odd_v[K-1];
        assign nb_st[DIR_W]    = st_v[K-1];
        assign nb_to_me[DIR_W] = par_v[K-1][DIR_E];
        assign gw              = ge_v[K-1];
      end else begin : g_nw
        assign nb_cid[DIR_W]   = '0;
        assign nb_odd[DIR_W]   = 1'b0;
        assign nb_st[DIR_W]    = 1'b0;
        assign nb_to_me[DIR_W] = 1'b0;
        assign gw              = 1'b0;
      end
      if (c < COLS - 1) begin : g_e
        assign nb_cid[DIR_E]   = cid_v[K+1];
        assign nb_odd[DIR_E]   = odd_v[K+1];
        assign nb_st[DIR_E]    = st_v[K+1];
        assign nb_to_me[DIR_E] = par_v[K+1][DIR_W];
      end else begin : g_ne
        assign nb_cid[DIR_E]   = '0;
        assign nb_odd[DIR_E]   = 1'b0;
        assign nb_st[DIR_E]    = 1'b0;
        assign nb_to_me[DIR_E] = 1'b0;
      end

      uf_pe #(
        .ID_W  (ID_W),
        .WEIGHT(WEIGHT),
        .MY_ID (K),
        .HAS_E (c < COLS - 1),
        .HAS_S (r < ROWS - 1)
      ) i_pe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (start_i),
        .defect_i   (defect_i[K]),
        .grow_en_i  (grow_en),
        .merge_en_i (merge_en),
        .nb_cid_i   (nb_cid),
        .nb_odd_i   (nb_odd),
        .nb_st_odd_i(nb_st),
        .nb_to_me_i (nb_to_me),
        .grown_n_i  (gn),
        .grown_w_i  (gw),
        .cid_o      (cid_v[K]),
        .odd_o      (odd_v[K]),
        .st_odd_o   (st_v[K]),
        .par_o      (par_v[K]),
        .grown_e_o  (ge_v[K]),
        .grown_s_o  (gs_v[K]),
        .root_odd_o (root_odd_v[K]),
        .busy_o     (busy_v[K])
      );
    end
  end

  assign grid_busy = |busy_v;

  uf_ctrl #(
    .CYCLE_LIMIT(CYCLE_LIMIT)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .grid_busy_i(grid_busy),
    .any_odd_i  (|root_odd_v),
    .grow_en_o  (grow_en),
    .merge_en_o (merge_en),
    .done_o     (done_o),
    .error_o    (error_o)
  );

  assign busy_o = grid_busy;
  assign cid_o  = cid_v;
endmodule

// File: rtl/uf_grid_checker.sv
module uf_grid_checker #(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  localparam int N_PE = ROWS * COLS,
  localparam int ID_W = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 error_o,
  input logic [N_PE*ID_W-1:0] cid_o
);
  logic ids_not_above_own;

  always_comb begin
    ids_not_above_own = 1'b1;
    for (int k = 0; k < N_PE; k++)
      if (int'(cid_o[k*ID_W +: ID_W]) > k) ids_not_above_own = 1'b0;
  end

  a_r1_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !error_o));

  a_r3_id_not_above_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ids_not_above_own);

  a_r4_done_error_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  a_r4_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(cid_o)));

  a_r5_error_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);

  a_r7_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind uf_grid_decoder uf_grid_checker #(
  .ROWS(ROWS),
  .COLS(COLS)
) i_uf_grid_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .error_o(error_o),
  .cid_o  (cid_o)
);

// File: tb/test_uf_grid_decoder.sv
`timescale 1ns / 1ps
module test_uf_grid_decoder;
  localparam int ROWS  = 3;
  localparam int COLS  = 3;
  localparam int N     = ROWS * COLS;
  localparam int ID_W  = 4;
  localparam int LIMIT = 400;

  logic             clk_i = 1'b0;
  logic             rst_ni, start_i;
  logic [N-1:0]     defect_i;
  logic             busy_o, done_o, error_o;
  logic [N*ID_W-1:0] cid_o;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #2.5 clk_i = ~clk_i;

  uf_grid_decoder #(.ROWS(ROWS), .COLS(COLS), .CYCLE_LIMIT(LIMIT)) i_uf_grid_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .defect_i(defect_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .cid_o(cid_o)
  );

  always @(posedge clk_i) begin
    wd++;
    if (wd > 190000) begin
      errors++;
      $display("FAIL R5 watchdog actual %0d expected below 190000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cid_of(input int k);
    return int'(cid_o[k*ID_W +: ID_W]);
  endfunction

  // arithmetic model: R2 growth rule, R3 min-id labelling
  task automatic model(input logic [N-1:0] def, output bit exp_done, output int lab[N]);
    int gh[N], gv[N], podd[N];
    bit anyodd, moved;
    for (int k = 0; k < N; k++) begin gh[k] = 0; gv[k] = 0; end
    exp_done = 1'b0;
    for (int round = 0; round < 64; round++) begin
      for (int k = 0; k < N; k++) lab[k] = k;
      for (int it = 0; it < N; it++) begin
        for (int k = 0; k < N; k++) begin
          if ((k % COLS) < COLS - 1 && gh[k] == 2) begin
            int m = (lab[k] < lab[k+1]) ? lab[k] : lab[k+1];
            lab[k] = m; lab[k+1] = m;
          end
          if ((k / COLS) < ROWS - 1 && gv[k] == 2) begin
            int m = (lab[k] < lab[k+COLS]) ? lab[k] : lab[k+COLS];
            lab[k] = m; lab[k+COLS] = m;
          end
        end
      end
      for (int k = 0; k < N; k++) podd[k] = 0;
      for (int k = 0; k < N; k++) podd[lab[k]] ^= int'(def[k]);
      anyodd = 1'b0;
      for (int k = 0; k < N; k++) if (podd[k] != 0) anyodd = 1'b1;
      if (!anyodd) begin exp_done = 1'b1; return; end
      moved = 1'b0;
      for (int k = 0; k < N; k++) begin
        if ((k % COLS) < COLS - 1 && gh[k] < 2) begin
          int inc = podd[lab[k]] + podd[lab[k+1]];
          if (inc > 0) begin gh[k] = (gh[k] + inc > 2) ? 2 : gh[k] + inc; moved = 1'b1; end
        end
        if ((k / COLS) < ROWS - 1 && gv[k] < 2) begin
          int inc = podd[lab[k]] + podd[lab[k+COLS]];
          if (inc > 0) begin gv[k] = (gv[k] + inc > 2) ? 2 : gv[k] + inc; moved = 1'b1; end
        end
      end
      if (!moved) return;
    end
  endtask

  task automatic run(input logic [N-1:0] pat, output int cyc, output bit saw_busy);
    @(negedge clk_i);
    defect_i = pat;
    start_i  = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && !error_o, "R1", "flags after start", {30'd0, done_o, error_o}, 0);
    cyc = 0;
    saw_busy = busy_o;
    while (!(done_o || error_o) && cyc < LIMIT + 20) begin
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
      if (busy_o) saw_busy = 1'b1;
    end
  endtask

  task automatic judge(input logic [N-1:0] pat, input int cyc);
    bit exp_done;
    int lab[N];
    model(pat, exp_done, lab);
    if (exp_done) begin
      chk(done_o && !error_o, "R4", $sformatf("done pattern %0d", pat), int'(done_o), 1);
      chk(!busy_o, "R7", "busy while done", int'(busy_o), 0);
      for (int k = 0; k < N; k++)
        chk(cid_of(k) == lab[k], "R2 R3", $sformatf("cid pe %0d pattern %0d", k, pat), cid_of(k), lab[k]);
    end else begin
      chk(error_o && !done_o, "R5", $sformatf("error pattern %0d", pat), int'(error_o), 1);
      chk(cyc == LIMIT, "R5", "cycles to error", cyc, LIMIT);
    end
  endtask

  initial begin
    int cyc;
    bit sb;
    rst_ni = 1'b0; start_i = 1'b0; defect_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !error_o, "R1", "flags after reset", {30'd0, done_o, error_o}, 0);
    for (int k = 0; k < N; k++) chk(cid_of(k) == k, "R1", "reset cid", cid_of(k), k);

    // R8 empty bitmap
    run('0, cyc, sb);
    chk(cyc == 1 && done_o, "R8", "cycles to done empty", cyc, 1);
    for (int k = 0; k < N; k++) chk(cid_of(k) == k, "R8", "empty cid", cid_of(k), k);

    // R7 adjacent pair must show busy; R4 hold
    run(9'b000000011, cyc, sb);
    chk(sb, "R7", "busy seen for adjacent pair", int'(sb), 1);
    judge(9'b000000011, cyc);
    repeat (3) @(negedge clk_i);
    chk(done_o, "R4", "done held", int'(done_o), 1);
    chk(cid_of(1) == 0, "R4", "cid held", cid_of(1), 0);

    // R6 restart mid-decode
    @(negedge clk_i);
    defect_i = 9'b000000001;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    run(9'b100000001, cyc, sb);
    chk(done_o, "R6", "restart outcome", int'(done_o), 1);
    judge(9'b100000001, cyc);

    // full sweep
    for (int p = 0; p < (1 << N); p++) begin
      run(p[N-1:0], cyc, sb);
      judge(p[N-1:0], cyc);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule